// File: doc/BRIEF.md
# Dual-Channel ADC Serial Readout Controller

This block is the host-side master for a converter that samples two channels at the same instant and returns each 12-bit result as a serial word. A one-cycle start request lowers an active-low select line. That edge starts the conversion and also frames the transfer. The block then toggles a serial clock that the converter also uses as its conversion clock. It captures two serial data inputs on the rising clock edges, because the converter changes its data on the falling edges.

Each channel word begins with two zero bits, followed by the 12 result bits, most significant first. A 16-clock word adds two trailing zeros. The mode input picks how the frame is read:

- 14 clocks on both lines.
- 16 clocks on both lines.
- 32 clocks on a single line, where the second channel's word follows the first.

The serial clock half-period is set by a divider parameter. After a frame, both samples and a framing-error flag update together with a one-cycle valid pulse. The select line is then held high for a guard interval before another frame may begin.

Top module: `dual_adc_reader`

## Requirements
- R1: During and after reset, `cs_n` and `sclk` are 1, `samp_valid` and `frame_err` are 0, and both samples are 0.
- R2: `cs_n` falls only in the cycle after `start` was seen high while the block was idle, and `sclk` is 1 whenever `cs_n` is 1.
- R3: While `cs_n` is 0, `sclk` is low for exactly DIV system clocks per period. A frame has 14 falling edges in mode 0, 16 in mode 1, and 32 in modes 2 and 3.
- R4: Data are sampled on the rising `sclk` edges, with the first sampled bit as the oldest. In mode 0, bit positions 0–1 are zero and positions 2–13 are the sample, MSB first. Channel A comes from `sdata_a` and channel B from `sdata_b`.
- R5: In mode 1, positions 0–1 and 14–15 are zero and positions 2–13 hold the sample, on both lines.
- R6: In mode 2, only `sdata_a` is read: positions 0–15 are channel A's word and positions 16–31 are channel B's word. In mode 3, only `sdata_b` is read: positions 0–15 are channel B's word and positions 16–31 are channel A's word.
- R7: `frame_err` is 1 exactly when a zero position of a line read in the current mode holds a 1. Unread lines and positions beyond the frame length have no effect.
- R8: `samp_valid` is a single-cycle pulse once per frame. `samp_a`, `samp_b` and `frame_err` change only in the cycle `samp_valid` is 1 and hold until the next pulse.
- R9: `cs_n` returns to 1 one system clock after the last rising `sclk` edge, is 1 when `samp_valid` is 1, and stays 1 for at least CS_GAP+1 system clocks before it falls again.
- R10: A `start` seen during a frame or the guard interval is dropped, not queued. `mode` is captured at start, and changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request, honoured only when idle |
| mode | input | 2 | 0: 14-clock dual line, 1: 16-clock dual line, 2: 32-clock on line A, 3: 32-clock on line B |
| sdata_a | input | 1 | Serial data line A |
| sdata_b | input | 1 | Serial data line B |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial and conversion clock, idle high |
| samp_a | output | DATA_W | Channel A result |
| samp_b | output | DATA_W | Channel B result |
| samp_valid | output | 1 | One-cycle pulse when new results are present |
| frame_err | output | 1 | A zero position in the read bits was nonzero |

## Verification
A wrong bit counter or a wrong latched mode shows up within one frame as the wrong number of `sclk` falling edges between the fall and rise of `cs_n`. The next `samp_valid` then shows it a second way: the sample bits are shifted, or the two channels are swapped. A wrong divider count shows as a wrong `sclk` low time, which is visible on the first clock period of a frame. A wrong guard counter, or a start that slips through while busy, shows as a short `cs_n` high interval or an extra frame at the ports, within a few cycles of the pulse.

// File: rtl/dar_pkg.sv
package dar_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL14 = 2'd0,
        MODE_DUAL16 = 2'd1,
        MODE_SGL_A  = 2'd2,
        MODE_SGL_B  = 2'd3
    } dar_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_GAP  = 2'd3
    } dar_state_e;

endpackage

// File: rtl/dar_frame_ctrl.sv
module dar_frame_ctrl
    import dar_pkg::*;
#(
    parameter int DIV       = 2,
    parameter int CS_GAP    = 4,
    parameter int SHORT_LEN = 14,
    parameter int WORD_LEN  = 16,
    parameter int LONG_LEN  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode_i,
    output logic       cs_n,
    output logic       sclk,
    output logic       sample_en,
    output logic       frame_done,
    output dar_mode_e  mode_lat
);

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam int CNT_W = $clog2(LONG_LEN);

    typedef struct packed {
        dar_state_e       st;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] bits;
        logic [GAP_W-1:0] gap;
        logic             sclk;
        logic             cs_n;
        dar_mode_e        mode;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic [CNT_W-1:0] last_bit;

    // Last rising-edge index of the frame, chosen by the latched mode.
    always_comb begin
        case (ctl_q.mode)
            MODE_DUAL14: last_bit = CNT_W'(SHORT_LEN - 1);
            MODE_DUAL16: last_bit = CNT_W'(WORD_LEN - 1);
            default:     last_bit = CNT_W'(LONG_LEN - 1);
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        sample_en  = 1'b0;
        frame_done = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.sclk = 1'b1;
                    ctl_d.div  = '0;
                    ctl_d.bits = '0;
                    ctl_d.mode = dar_mode_e'(mode_i);
                end
            end
            ST_RUN: begin
                if (ctl_q.div == DIV_W'(DIV - 1)) begin
                    ctl_d.div  = '0;
                    ctl_d.sclk = ~ctl_q.sclk;
                    if (!ctl_q.sclk) begin
                        // rising edge: data shifted on the prior fall is stable
                        sample_en = 1'b1;
                        if (ctl_q.bits == last_bit) begin
                            ctl_d.st = ST_DONE;
                        end else begin
                            ctl_d.bits = ctl_q.bits + 1'b1;
                        end
                    end
                end else begin
                    ctl_d.div = ctl_q.div + 1'b1;
                end
            end
            ST_DONE: begin
                ctl_d.cs_n = 1'b1;
                ctl_d.gap  = '0;
                ctl_d.st   = ST_GAP;
                frame_done = 1'b1;
            end
            default: begin
                if (ctl_q.gap == GAP_W'(CS_GAP - 1)) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.gap = ctl_q.gap + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, div: '0, bits: '0, gap: '0,
                       sclk: 1'b1, cs_n: 1'b1, mode: MODE_DUAL14};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_n     = ctl_q.cs_n;
    assign sclk     = ctl_q.sclk;
    assign mode_lat = ctl_q.mode;

endmodule

// File: rtl/dar_shift_capture.sv
module dar_shift_capture #(
    parameter int LEN = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] word
);

    logic [LEN-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_en) begin
            word_d = {word_q[LEN-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/dar_unpack.sv
module dar_unpack
    import dar_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LEAD_W  = 2,
    parameter int TRAIL_W = 2
) (
    input  dar_mode_e                                mode,
    input  logic [2*(LEAD_W+DATA_W+TRAIL_W)-1:0]     line_a,
    input  logic [2*(LEAD_W+DATA_W+TRAIL_W)-1:0]     line_b,
    output logic [DATA_W-1:0]                        samp_a,
    output logic [DATA_W-1:0]                        samp_b,
    output logic                                     bad
);

    localparam int SHORT_LEN = LEAD_W + DATA_W;
    localparam int WORD_LEN  = SHORT_LEN + TRAIL_W;
    localparam int LONG_LEN  = 2 * WORD_LEN;

    function automatic logic [DATA_W-1:0] word_data(input logic [WORD_LEN-1:0] w);
        return w[WORD_LEN-LEAD_W-1:TRAIL_W];
    endfunction

    function automatic logic word_bad(input logic [WORD_LEN-1:0] w);
        return (|w[WORD_LEN-1:WORD_LEN-LEAD_W]) | (|w[TRAIL_W-1:0]);
    endfunction

    // Newest bit sits at index 0; the oldest word of a long frame is the upper half.
    always_comb begin
        case (mode)
            MODE_DUAL14: begin
                samp_a = line_a[DATA_W-1:0];
                samp_b = line_b[DATA_W-1:0];
                bad    = (|line_a[SHORT_LEN-1:DATA_W]) | (|line_b[SHORT_LEN-1:DATA_W]);
            end
            MODE_DUAL16: begin
                samp_a = word_data(line_a[WORD_LEN-1:0]);
                samp_b = word_data(line_b[WORD_LEN-1:0]);
                bad    = word_bad(line_a[WORD_LEN-1:0]) | word_bad(line_b[WORD_LEN-1:0]);
            end
            MODE_SGL_A: begin
                samp_a = word_data(line_a[LONG_LEN-1:WORD_LEN]);
                samp_b = word_data(line_a[WORD_LEN-1:0]);
                bad    = word_bad(line_a[LONG_LEN-1:WORD_LEN]) | word_bad(line_a[WORD_LEN-1:0]);
            end
            default: begin
                samp_b = word_data(line_b[LONG_LEN-1:WORD_LEN]);
                samp_a = word_data(line_b[WORD_LEN-1:0]);
                bad    = word_bad(line_b[LONG_LEN-1:WORD_LEN]) | word_bad(line_b[WORD_LEN-1:0]);
            end
        endcase
    end

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import dar_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LEAD_W  = 2,
    parameter int TRAIL_W = 2,
    parameter int DIV     = 2,
    parameter int CS_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              sdata_a,
    input  logic              sdata_b,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] samp_a,
    output logic [DATA_W-1:0] samp_b,
    output logic              samp_valid,
    output logic              frame_err
);

    localparam int SHORT_LEN = LEAD_W + DATA_W;
    localparam int WORD_LEN  = SHORT_LEN + TRAIL_W;
    localparam int LONG_LEN  = 2 * WORD_LEN;
    localparam int NUM_LINES = 2;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              vld;
        logic              err;
    } res_t;

    logic                 sample_en;
    logic                 frame_done;
    dar_mode_e            mode_lat;
    logic [NUM_LINES-1:0] sdata_vec;
    logic [LONG_LEN-1:0]  line_word [NUM_LINES];
    logic [DATA_W-1:0]    dec_a, dec_b;
    logic                 dec_bad;
    res_t                 res_d, res_q;

    assign sdata_vec = {sdata_b, sdata_a};

    dar_frame_ctrl #(
        .DIV       (DIV),
        .CS_GAP    (CS_GAP),
        .SHORT_LEN (SHORT_LEN),
        .WORD_LEN  (WORD_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_i     (mode),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sample_en  (sample_en),
        .frame_done (frame_done),
        .mode_lat   (mode_lat)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        dar_shift_capture #(
            .LEN (LONG_LEN)
        ) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (sample_en),
            .din      (sdata_vec[g]),
            .word     (line_word[g])
        );
    end

    dar_unpack #(
        .DATA_W  (DATA_W),
        .LEAD_W  (LEAD_W),
        .TRAIL_W (TRAIL_W)
    ) u_unpack (
        .mode   (mode_lat),
        .line_a (line_word[0]),
        .line_b (line_word[1]),
        .samp_a (dec_a),
        .samp_b (dec_b),
        .bad    (dec_bad)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        if (frame_done) begin
            res_d.a   = dec_a;
            res_d.b   = dec_b;
            res_d.err = dec_bad;
            res_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign samp_a     = res_q.a;
    assign samp_b     = res_q.b;
    assign samp_valid = res_q.vld;
    assign frame_err  = res_q.err;

endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
    parameter int DATA_W = 12,
    parameter int CS_GAP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cs_n,
    input logic              sclk,
    input logic [DATA_W-1:0] samp_a,
    input logic [DATA_W-1:0] samp_b,
    input logic              samp_valid,
    input logic              frame_err
);

    localparam int GW = $clog2(CS_GAP + 1) + 1;

    // Cycles cs_n has been high, saturating at CS_GAP.
    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= GW'(CS_GAP);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < GW'(CS_GAP)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    p_cs_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start));

    p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> !samp_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |-> ($stable(samp_a) && $stable(samp_b) && $stable(frame_err)));

    p_valid_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> cs_n);

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && hi_cnt < GW'(CS_GAP)) |=> cs_n);

endmodule

bind dual_adc_reader dual_adc_reader_chk #(
    .DATA_W (DATA_W),
    .CS_GAP (CS_GAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .samp_a     (samp_a),
    .samp_b     (samp_b),
    .samp_valid (samp_valid),
    .frame_err  (frame_err)
);

// File: tb/dual_adc_reader_tb.sv
module dual_adc_reader_tb;

    localparam int DIV    = 2;
    localparam int CS_GAP = 4;
    localparam int DW     = 12;

    logic          clk = 1'b0;
    logic          rst_n, start;
    logic [1:0]    mode;
    logic          sdata_a = 1'b0, sdata_b = 1'b0;
    logic          cs_n, sclk, samp_valid, frame_err;
    logic [DW-1:0] samp_a, samp_b;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    dual_adc_reader #(.DATA_W(DW), .DIV(DIV), .CS_GAP(CS_GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .sdata_a(sdata_a), .sdata_b(sdata_b), .cs_n(cs_n), .sclk(sclk),
        .samp_a(samp_a), .samp_b(samp_b), .samp_valid(samp_valid),
        .frame_err(frame_err)
    );

    // Converter model and port monitor, both on the falling system edge.
    logic [31:0] str_a = '0, str_b = '0;
    int   idx = 0, fall_cnt = 0, cs_falls = 0, hi_run = 0, lo_run = 0;
    int   frames_seen = 0, min_gap = 1000, bad_half = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                idx = 0;
                fall_cnt = 0;
                cs_falls++;
                if (frames_seen > 0 && hi_run < min_gap) min_gap = hi_run;
            end
            if (!cs_n && prev_sclk && !sclk) begin
                sdata_a <= (idx < 32) ? str_a[31-idx] : 1'b0;
                sdata_b <= (idx < 32) ? str_b[31-idx] : 1'b0;
                idx++;
                fall_cnt++;
            end
            if (!sclk) lo_run++;
            if (!prev_sclk && sclk) begin
                if (lo_run != DIV) bad_half++;
                lo_run = 0;
            end
            hi_run = cs_n ? hi_run + 1 : 0;
            if (samp_valid) frames_seen++;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input int m);
        return (m == 0) ? 14 : (m == 1) ? 16 : 32;
    endfunction

    function automatic bit zero_slot(input int m, input int p);
        int q = p % 16;
        if (m == 0) return p < 2;
        if (m == 1) return (p < 2) || (p >= 14 && p < 16);
        return (q < 2) || (q >= 14);
    endfunction

    function automatic bit line_read(input int m, input int ln);
        if (m == 2) return ln == 0;
        if (m == 3) return ln == 1;
        return 1'b1;
    endfunction

    function automatic bit exp_err(input int m, input int p, input int ln);
        if (p < 0) return 1'b0;
        return (p < frame_len(m)) && zero_slot(m, p) && line_read(m, ln);
    endfunction

    task automatic do_frame(input int m, input logic [DW-1:0] a, input logic [DW-1:0] b,
                            input int cpos, input int cline, input int m_after);
        logic [31:0] wa, wb;
        bit e;
        wa = {2'b00, a, 2'b00, 2'b00, b, 2'b00};
        wb = {2'b00, b, 2'b00, 2'b00, a, 2'b00};
        if (cpos >= 0) begin
            if (cline == 0) wa[31-cpos] = ~wa[31-cpos];
            else            wb[31-cpos] = ~wb[31-cpos];
        end
        str_a = wa;
        str_b = wb;
        mode  = m[1:0];
        start = 1'b1;
        @(negedge clk);
        while (cs_n) @(negedge clk);
        start = 1'b0;
        mode  = m_after[1:0];
        while (!samp_valid) @(negedge clk);
        e = exp_err(m, cpos, cline);
        check(samp_a == a, "R4/R5/R6/R10 samp_a", samp_a, a);
        check(samp_b == b, "R4/R5/R6/R10 samp_b", samp_b, b);
        check(frame_err == e, "R7 frame_err", frame_err, e);
        check(fall_cnt == frame_len(m), "R3 sclk falls per frame", fall_cnt, frame_len(m));
        check(cs_n == 1'b1, "R9 cs_n high at valid", cs_n, 1);
        @(negedge clk);
        check(samp_valid == 1'b0, "R8 valid single cycle", samp_valid, 0);
    endtask

    int   c0;
    int   m_r, p_r, ln_r;
    logic [DW-1:0] a_r, b_r;

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0;
        start = 1'b0;
        mode  = 2'd0;
        repeat (5) @(negedge clk);
        check(cs_n == 1 && sclk == 1, "R1 cs_n/sclk in reset", {cs_n, sclk}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1 && sclk == 1, "R1 cs_n/sclk after reset", {cs_n, sclk}, 2'b11);
        check(samp_valid == 0 && frame_err == 0, "R1 flags", {samp_valid, frame_err}, 0);
        check(samp_a == 0 && samp_b == 0, "R1 samples", {samp_a, samp_b}, 0);

        do_frame(0, 12'hABC, 12'h123, -1, 0, 0);   // R4
        do_frame(1, 12'hFFF, 12'h000, -1, 0, 1);   // R5
        do_frame(2, 12'h5A5, 12'hA5A, -1, 0, 2);   // R6 line A
        do_frame(3, 12'h0F0, 12'hF0F, -1, 0, 3);   // R6 line B
        do_frame(1, 12'h321, 12'h654, 15, 1, 1);   // R7 trailing zero on B
        do_frame(0, 12'h800, 12'h001, 1, 0, 0);    // R7 leading zero on A
        do_frame(0, 12'h111, 12'h222, 15, 0, 0);   // R7 beyond 14-clock frame
        do_frame(2, 12'h333, 12'h444, 0, 1, 2);    // R7 unread line
        do_frame(2, 12'h555, 12'h666, 17, 0, 2);   // R7 second word lead
        do_frame(3, 12'h777, 12'h888, 30, 1, 3);   // R7 second word trail
        do_frame(0, 12'h9AB, 12'hCDE, -1, 0, 2);   // R10 mode change mid-frame

        // R10: starts during a frame and during the guard interval are dropped
        c0 = cs_falls;
        fork
            do_frame(2, 12'h246, 12'h8AC, -1, 0, 2);
            begin
                repeat (20) begin
                    repeat (3) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        check(cs_falls == c0 + 1, "R10 busy starts dropped", cs_falls, c0 + 1);
        check(cs_n == 1'b1, "R10 idle after dropped starts", cs_n, 1);

        // R9: back-to-back frames with start held high
        str_a = {2'b00, 12'h135, 4'b0000, 12'h79B, 2'b00};
        str_b = {2'b00, 12'h79B, 4'b0000, 12'h135, 2'b00};
        mode  = 2'd1;
        start = 1'b1;
        repeat (2) begin
            @(negedge clk);
            while (!samp_valid) @(negedge clk);
        end
        start = 1'b0;
        check(samp_a == 12'h135 && samp_b == 12'h79B, "R5 back-to-back data",
              {samp_a, samp_b}, {12'h135, 12'h79B});
        repeat (20) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            m_r = int'($urandom % 4);
            a_r = DW'($urandom);
            b_r = DW'($urandom);
            p_r = -1;
            ln_r = int'($urandom % 2);
            if ($urandom % 3 == 0) begin
                do p_r = int'($urandom % 32);
                while (!(zero_slot(m_r, p_r) || p_r >= frame_len(m_r)));
            end
            do_frame(m_r, a_r, b_r, p_r, ln_r, int'($urandom % 4));
        end

        check(bad_half == 0, "R3 sclk low time", bad_half, 0);
        check(min_gap >= CS_GAP + 1, "R9 cs_n high interval", min_gap, CS_GAP + 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule